// File: doc/BRIEF.md
# Touch Pressure Resistance Calculator

This block turns the readings of a four-wire resistive panel into an estimate of the resistance at the point of touch. The inputs are the 12-bit X and Y position codes, the two cross-panel codes Z1 and Z2, and the resistances of the X and Y plates in ohms. A host presents all operands together with a one-cycle start request. Some cycles later the block returns the resistance, a one-cycle completion pulse and an error flag.

Two formulas are offered, chosen by a select input. Both scale the X position against a full scale of 4096. One formula uses the ratio Z2/Z1. The other uses 4096/Z1 and subtracts a Y-plate term. The ratio is formed by a restoring divider that produces one quotient bit per clock and keeps 8 fractional bits. The final products are then formed in a single cycle. A zero Z1 code is detected before any division starts.

Top module: `touch_res_calc`

## Requirements
- R1: With `method_sel`=0, the result is floor(Rx·X·T/2^20). Here T = max(0, Q − 256) and Q = floor(Z2·256/Z1).
- R2: With `method_sel`=1, the result is max(0, A − B). Here A = floor(Rx·X·T/2^20), T = max(0, Q − 256) and Q = floor(2^20/Z1). B = floor(Ry·(4096 − Y)/2^12).
- R3: When Z1 is 0, `err` is 1 in the completion cycle and `r_touch` is all ones (16777215). No division is started in this case.
- R4: A negative intermediate value clamps the result to 0. In the first method this happens when Z2 < Z1. In the second method it happens when B exceeds A. In both cases `err` is 0.
- R5: `done` is high for exactly one cycle per accepted request. `r_touch` and `err` change only in that cycle and hold their values until the next completion.
- R6: A `start` that arrives while a calculation is in progress is ignored. Its operands do not affect the result, and it produces no extra completion.
- R7: While `rst_n` is low at a clock edge, `done`, `err` and `r_touch` become 0 after that edge. This also holds when reset arrives in the middle of a calculation.
- R8: Completion comes no more than 24 clock edges after the edge that accepted `start`, counting that edge. With Z1 = 0, completion comes on the very edge that accepted the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a calculation; taken only when idle |
| method_sel | input | 1 | 0 selects the Z2-ratio formula, 1 the two-plate formula |
| x_pos | input | 12 | X position code |
| y_pos | input | 12 | Y position code |
| z1_code | input | 12 | First cross-panel code |
| z2_code | input | 12 | Second cross-panel code |
| rx_ohm | input | 12 | X-plate resistance in ohms |
| ry_ohm | input | 12 | Y-plate resistance in ohms |
| r_touch | output | 24 | Computed touch resistance in ohms |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Z1 was zero for the completed request |

## Verification
Several properties are checked on every cycle. The completion pulse lasts one cycle, and the outputs stay still between completions. The error flag matches a zero Z1 captured at acceptance, and an error always comes with a saturated result. Completion never exceeds the 24-edge bound, and reset clears the outputs. The arithmetic itself can only be shown by the bench scenarios, which compare against values computed from the formulas. These include both methods, the clamp to zero, the maximum operands, ignored requests while busy, and reset in the middle of a calculation.

// File: rtl/tpc_pkg.sv
// Package: shared widths and the controller state type for the touch
// resistance calculator. Assumes 12-bit codes and 8 fractional quotient bits.
package tpc_pkg;
    localparam int CODE_W = 12;   // position / cross-panel code width
    localparam int RES_W  = 12;   // plate resistance width
    localparam int FRAC_W = 8;    // fractional bits of the divider quotient
    localparam int OUT_W  = 24;   // result width

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIV  = 2'd1,
        ST_MUL  = 2'd2
    } calc_state_t;
endpackage

// File: rtl/tpc_div.sv
// Restoring divider: returns floor(num/den) after NUM_W cycles, one quotient
// bit per clock. Assumes den is nonzero (the caller screens zero); go loads
// the operands, vld pulses for one cycle when quo is final.
module tpc_div #(
    parameter int NUM_W = 21,
    parameter int DEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quo,
    output logic             vld
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] cnt_q;
    logic [DEN_W:0]   trial;
    logic             fits;
    logic [DEN_W-1:0] rem_nxt;

    // Purpose: one restoring step - shift in the next dividend bit, try a subtract.
    always_comb begin
        trial   = {rem_q, quo[NUM_W-1]};
        fits    = (trial >= {1'b0, den_q});
        rem_nxt = fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
    end

    // Purpose: load operands on go, then iterate and flag the final step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            den_q <= '0;
            quo   <= '0;
            cnt_q <= '0;
            vld   <= 1'b0;
        end else begin
            vld <= 1'b0;
            if (go) begin
                rem_q <= '0;
                den_q <= den;
                quo   <= num;
                cnt_q <= CNT_W'(NUM_W);
            end else if (cnt_q != '0) begin
                rem_q <= rem_nxt;
                quo   <= {quo[NUM_W-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                vld   <= (cnt_q == CNT_W'(1));
            end
        end
    end
endmodule

// File: rtl/tpc_scale.sv
// Combinational scaler: turns the fixed-point quotient into ohms.
// The X term is Rx*X*max(0,q-1.0) >> (CODE_W+FRAC_W). With two_plate set,
// the Y term Ry*(full-Y) >> CODE_W is subtracted. The result is clamped at
// zero and saturated at the output width.
module tpc_scale #(
    parameter int CODE_W = 12,
    parameter int RES_W  = 12,
    parameter int FRAC_W = 8,
    parameter int Q_W    = 21,
    parameter int OUT_W  = 24
) (
    input  logic              two_plate,
    input  logic [RES_W-1:0]  rx,
    input  logic [RES_W-1:0]  ry,
    input  logic [CODE_W-1:0] xp,
    input  logic [CODE_W-1:0] yp,
    input  logic [Q_W-1:0]    q,
    output logic [OUT_W-1:0]  res
);
    localparam int PW = RES_W + CODE_W + Q_W;
    localparam int BW = RES_W + CODE_W + 1;
    localparam int SH = CODE_W + FRAC_W;
    localparam logic [Q_W-1:0]    ONE  = Q_W'(1) << FRAC_W;
    localparam logic [CODE_W:0]   FULL = (CODE_W + 1)'(1) << CODE_W;

    logic [Q_W-1:0]    t_mag;
    logic [PW-1:0]     prod_a;
    logic [PW-1:0]     a_val;
    logic [CODE_W:0]   span;
    logic [BW-1:0]     prod_b;
    logic [PW-1:0]     b_val;
    logic [PW-1:0]     diff;

    // Purpose: X-plate term with the one-unit offset removed and clamped at zero.
    always_comb begin
        t_mag  = (q > ONE) ? (q - ONE) : '0;
        prod_a = PW'(rx) * PW'(xp) * PW'(t_mag);
        a_val  = prod_a >> SH;
    end

    // Purpose: Y-plate correction and the clamped difference.
    always_comb begin
        span   = FULL - {1'b0, yp};
        prod_b = BW'(ry) * BW'(span);
        b_val  = PW'(prod_b >> CODE_W);
        if (!two_plate)
            diff = a_val;
        else if (b_val > a_val)
            diff = '0;
        else
            diff = a_val - b_val;
    end

    // Purpose: fit the difference into the output width.
    generate
        if (PW > OUT_W) begin : g_sat
            always_comb begin
                if (diff[PW-1:OUT_W] != '0)
                    res = '1;
                else
                    res = diff[OUT_W-1:0];
            end
        end else begin : g_wide
            always_comb res = OUT_W'(diff);
        end
    endgenerate
endmodule

// File: rtl/tpc_ctrl.sv
// Controller: accepts a request only when idle and captures the operands.
// It screens Z1 = 0 (immediate saturated error completion), launches the
// divider, then registers the scaled result with a one-cycle done pulse.
module tpc_ctrl
    import tpc_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int RES_W  = 12,
    parameter int FRAC_W = 8,
    parameter int Q_W    = 21,
    parameter int OUT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              method_sel,
    input  logic [CODE_W-1:0] x_pos,
    input  logic [CODE_W-1:0] y_pos,
    input  logic [CODE_W-1:0] z1_code,
    input  logic [CODE_W-1:0] z2_code,
    input  logic [RES_W-1:0]  rx_ohm,
    input  logic [RES_W-1:0]  ry_ohm,
    output logic              div_go,
    output logic [Q_W-1:0]    div_num,
    input  logic [Q_W-1:0]    div_quo,
    input  logic              div_vld,
    input  logic [OUT_W-1:0]  scaled,
    output logic              cap_method,
    output logic [RES_W-1:0]  cap_rx,
    output logic [RES_W-1:0]  cap_ry,
    output logic [CODE_W-1:0] cap_x,
    output logic [CODE_W-1:0] cap_y,
    output logic [Q_W-1:0]    cap_q,
    output logic              busy,
    output logic [OUT_W-1:0]  r_touch,
    output logic              done,
    output logic              err
);
    calc_state_t state_q;
    logic        accept;
    logic        z1_zero;

    // Purpose: request acceptance and the dividend chosen by the method.
    always_comb begin
        accept  = (state_q == ST_IDLE) && start;
        z1_zero = (z1_code == '0);
        div_go  = accept && !z1_zero;
        if (method_sel)
            div_num = Q_W'(1) << (CODE_W + FRAC_W);
        else
            div_num = Q_W'({z2_code, {FRAC_W{1'b0}}});
        busy = (state_q != ST_IDLE);
    end

    // Purpose: sequence accept -> divide -> scale, and drive the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cap_method <= 1'b0;
            cap_rx     <= '0;
            cap_ry     <= '0;
            cap_x      <= '0;
            cap_y      <= '0;
            cap_q      <= '0;
            r_touch    <= '0;
            done       <= 1'b0;
            err        <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        cap_method <= method_sel;
                        cap_rx     <= rx_ohm;
                        cap_ry     <= ry_ohm;
                        cap_x      <= x_pos;
                        cap_y      <= y_pos;
                        if (z1_zero) begin
                            r_touch <= '1;
                            err     <= 1'b1;
                            done    <= 1'b1;
                        end else begin
                            state_q <= ST_DIV;
                        end
                    end
                end
                ST_DIV: begin
                    if (div_vld) begin
                        cap_q   <= div_quo;
                        state_q <= ST_MUL;
                    end
                end
                ST_MUL: begin
                    r_touch <= scaled;
                    err     <= 1'b0;
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/touch_res_calc.sv
// Top: touch resistance calculator. Combines the controller, the restoring
// divider and the scaler. Assumes inputs are held by the host only for the
// start cycle; all operands are captured at acceptance.
module touch_res_calc
    import tpc_pkg::*;
#(
    parameter int CODE_W = tpc_pkg::CODE_W,
    parameter int RES_W  = tpc_pkg::RES_W,
    parameter int FRAC_W = tpc_pkg::FRAC_W,
    parameter int OUT_W  = tpc_pkg::OUT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              method_sel,
    input  logic [CODE_W-1:0] x_pos,
    input  logic [CODE_W-1:0] y_pos,
    input  logic [CODE_W-1:0] z1_code,
    input  logic [CODE_W-1:0] z2_code,
    input  logic [RES_W-1:0]  rx_ohm,
    input  logic [RES_W-1:0]  ry_ohm,
    output logic [OUT_W-1:0]  r_touch,
    output logic              done,
    output logic              err
);
    localparam int Q_W = CODE_W + FRAC_W + 1;

    logic              div_go;
    logic [Q_W-1:0]    div_num;
    logic [Q_W-1:0]    div_quo;
    logic              div_vld;
    logic [OUT_W-1:0]  scaled;
    logic              cap_method;
    logic [RES_W-1:0]  cap_rx;
    logic [RES_W-1:0]  cap_ry;
    logic [CODE_W-1:0] cap_x;
    logic [CODE_W-1:0] cap_y;
    logic [Q_W-1:0]    cap_q;
    logic              busy;

    tpc_ctrl #(
        .CODE_W(CODE_W), .RES_W(RES_W), .FRAC_W(FRAC_W), .Q_W(Q_W), .OUT_W(OUT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .method_sel(method_sel),
        .x_pos(x_pos), .y_pos(y_pos), .z1_code(z1_code), .z2_code(z2_code),
        .rx_ohm(rx_ohm), .ry_ohm(ry_ohm),
        .div_go(div_go), .div_num(div_num), .div_quo(div_quo), .div_vld(div_vld),
        .scaled(scaled), .cap_method(cap_method), .cap_rx(cap_rx), .cap_ry(cap_ry),
        .cap_x(cap_x), .cap_y(cap_y), .cap_q(cap_q), .busy(busy),
        .r_touch(r_touch), .done(done), .err(err)
    );

    tpc_div #(.NUM_W(Q_W), .DEN_W(CODE_W)) u_div (
        .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num), .den(z1_code),
        .quo(div_quo), .vld(div_vld)
    );

    tpc_scale #(
        .CODE_W(CODE_W), .RES_W(RES_W), .FRAC_W(FRAC_W), .Q_W(Q_W), .OUT_W(OUT_W)
    ) u_scale (
        .two_plate(cap_method), .rx(cap_rx), .ry(cap_ry), .xp(cap_x), .yp(cap_y),
        .q(cap_q), .res(scaled)
    );
endmodule

// File: rtl/tpc_chk.sv
// Checker: cycle-level properties of the touch resistance calculator,
// bound to the top. Tracks Z1 at acceptance and the cycles since acceptance.
module tpc_chk #(
    parameter int CODE_W = 12,
    parameter int OUT_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic [CODE_W-1:0] z1_code,
    input logic [OUT_W-1:0]  r_touch,
    input logic              done,
    input logic              err
);
    logic [CODE_W-1:0] z1_seen;
    logic [5:0]        age;

    // Purpose: remember Z1 of the accepted request and count edges since it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z1_seen <= '0;
            age     <= '0;
        end else if (start && !busy) begin
            z1_seen <= z1_code;
            age     <= 6'd1;
        end else if (done) begin
            age     <= '0;
        end else if (age != '0) begin
            age     <= age + 1'b1;
        end
    end

    // R5: completion pulse is one cycle wide
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: result holds between completions
    a_r5_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && $past(rst_n)) |-> ($stable(r_touch) && $stable(err)));

    // R3: error flag matches a zero Z1 captured at acceptance
    a_r3_err_iff_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err == (z1_seen == '0)));

    // R3: an error result is saturated
    a_r3_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (r_touch == '1));

    // R8: completion bound
    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        age <= 6'd24);

    // R7: reset clears outputs
    a_r7_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!done && !err && r_touch == '0));
endmodule

bind touch_res_calc tpc_chk #(.CODE_W(CODE_W), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .z1_code(z1_code),
    .r_touch(r_touch), .done(done), .err(err)
);

// File: tb/sim_touch_res_calc.sv
`timescale 1ns/1ps
module sim_touch_res_calc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        method_sel = 1'b0;
    logic [11:0] x_pos = '0, y_pos = '0, z1_code = '0, z2_code = '0;
    logic [11:0] rx_ohm = '0, ry_ohm = '0;
    logic [23:0] r_touch;
    logic        done, err;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    touch_res_calc u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .method_sel(method_sel),
        .x_pos(x_pos), .y_pos(y_pos), .z1_code(z1_code), .z2_code(z2_code),
        .rx_ohm(rx_ohm), .ry_ohm(ry_ohm), .r_touch(r_touch), .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected result computed from the formulas in R1, R2 and R4.
    function automatic longint model(input bit m, input longint rx, input longint ry,
                                     input longint x, input longint y,
                                     input longint z1, input longint z2);
        longint q, t, a, b, r;
        q = m ? (64'd1048576 / z1) : ((z2 * 256) / z1);
        t = q - 256;
        if (t < 0) t = 0;
        a = (rx * x * t) >>> 20;
        b = m ? ((ry * (4096 - y)) >>> 12) : 0;
        r = a - b;
        if (r < 0) r = 0;
        if (r > 16777215) r = 16777215;
        return r;
    endfunction

    // Issue one request and wait for completion; lat counts edges from acceptance.
    task automatic run_op(input bit m, input int rx, input int ry, input int x,
                          input int y, input int z1, input int z2, output int lat);
        @(negedge clk);
        method_sel = m; rx_ohm = 12'(rx); ry_ohm = 12'(ry);
        x_pos = 12'(x); y_pos = 12'(y); z1_code = 12'(z1); z2_code = 12'(z2);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_calc(input string req, input bit m, input int rx, input int ry,
                              input int x, input int y, input int z1, input int z2);
        int lat;
        longint exp_r;
        exp_r = model(m, rx, ry, x, y, z1, z2);
        run_op(m, rx, ry, x, y, z1, z2, lat);
        chk(done === 1'b1, {req, " done seen"}, done, 1);
        chk(r_touch == 24'(exp_r), {req, " result"}, r_touch, exp_r);
        chk(err === 1'b0, {req, " err clear"}, err, 0);
        chk(lat <= 24, "R8 latency bound", lat, 24);
    endtask

    task automatic t_reset_state;
        chk(done === 1'b0, "R7 reset done", done, 0);
        chk(err === 1'b0, "R7 reset err", err, 0);
        chk(r_touch === 24'd0, "R7 reset result", r_touch, 0);
    endtask

    task automatic t_method_ratio;
        check_calc("R1 typical", 1'b0, 600, 0, 2048, 0, 1000, 3000);
        check_calc("R1 small ratio", 1'b0, 1234, 0, 3071, 0, 777, 901);
        check_calc("R1 z1=1", 1'b0, 4095, 0, 4095, 0, 1, 4095);
    endtask

    task automatic t_method_plates;
        check_calc("R2 typical", 1'b1, 800, 300, 1500, 2000, 1200, 0);
        check_calc("R2 max codes", 1'b1, 4095, 4095, 4095, 4095, 4095, 0);
        check_calc("R2 y=0", 1'b1, 2000, 100, 3000, 0, 513, 0);
    endtask

    task automatic t_clamp;
        check_calc("R4 ratio below one", 1'b0, 900, 0, 2500, 0, 3000, 1000);
        check_calc("R4 plate term wins", 1'b1, 100, 4000, 50, 10, 3500, 0);
    endtask

    task automatic t_zero_z1;
        int lat;
        run_op(1'b0, 500, 0, 1000, 0, 0, 2000, lat);
        chk(err === 1'b1, "R3 err for zero z1 method 0", err, 1);
        chk(r_touch == 24'hFFFFFF, "R3 saturate method 0", r_touch, 24'hFFFFFF);
        chk(lat == 1, "R8 zero z1 immediate", lat, 1);
        run_op(1'b1, 500, 200, 1000, 100, 0, 0, lat);
        chk(err === 1'b1, "R3 err for zero z1 method 1", err, 1);
        chk(r_touch == 24'hFFFFFF, "R3 saturate method 1", r_touch, 24'hFFFFFF);
        // a following valid request clears the error
        check_calc("R3 err cleared after valid op", 1'b0, 600, 0, 2048, 0, 1000, 3000);
    endtask

    task automatic t_pulse_hold;
        int lat;
        longint exp_r;
        exp_r = model(1'b1, 1000, 200, 2222, 1111, 1500, 0);
        run_op(1'b1, 1000, 200, 2222, 1111, 1500, 0, lat);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(done === 1'b0, "R5 done one cycle", done, 0);
            chk(r_touch == 24'(exp_r), "R5 result held", r_touch, exp_r);
        end
    endtask

    task automatic t_busy_ignore;
        longint exp_r;
        int n;
        int extra;
        exp_r = model(1'b0, 700, 0, 3000, 0, 1100, 2900);
        @(negedge clk);
        method_sel = 1'b0; rx_ohm = 12'd700; x_pos = 12'd3000;
        z1_code = 12'd1100; z2_code = 12'd2900; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        method_sel = 1'b1; rx_ohm = 12'd50; ry_ohm = 12'd9; x_pos = 12'd5;
        z1_code = 12'd0; z2_code = 12'd1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        n = 0;
        while (!done && n < 40) begin @(negedge clk); n++; end
        chk(r_touch == 24'(exp_r), "R6 ignored start leaves result", r_touch, exp_r);
        chk(err === 1'b0, "R6 ignored zero z1 no error", err, 0);
        extra = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk(extra == 0, "R6 no extra completion", extra, 0);
    endtask

    task automatic t_reset_mid;
        @(negedge clk);
        method_sel = 1'b0; rx_ohm = 12'd300; x_pos = 12'd300;
        z1_code = 12'd10; z2_code = 12'd4000; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(r_touch === 24'd0 && done === 1'b0 && err === 1'b0,
            "R7 reset mid calculation", r_touch, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            chk(done === 1'b0, "R7 no completion after reset", done, 0);
        end
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_method_ratio();
        t_method_plates();
        t_clamp();
        t_zero_z1();
        t_pulse_hold();
        t_busy_ignore();
        t_reset_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule